// File: doc/BRIEF.md
# Multi-IO Serial Flash Phase Sequencer

This block runs one serial-flash style operation as a fixed chain of phases: an opcode phase, a combined address-and-dummy phase, and an optional data phase that either writes to or reads from the device. Each phase picks its own IO lane width, so a single-lane opcode can be followed by address bytes on one, two or four lanes and a data phase that drives or releases the lanes. Outgoing bytes are pulled from a byte stream with a valid/ready handshake. Bytes read from the device come out as one-cycle pulses.

The block does not divide the clock. An external strobe, `shift_en`, grants one bit slot. The sequencer uses it only when a slot can start. The serial clock output is high for the one cycle that follows each accepted strobe, and the device samples and drives around that pulse. All configuration is captured on `start`, so software may change the configuration inputs as soon as the operation has begun.

Top module: `mflash_phase_seq`

## Requirements
- R1: After synchronous reset, `cs_n` is 1 and `sck`, `io_oe`, `done`, `busy`, `rx_valid` and `tx_ready` are all 0.
- R2: The opcode phase sends `cfg_op_bytes` bytes from the stream, MSB first, one bit per slot on IO0 with `io_oe` = 4'b0001. A count of 0 skips the phase.
- R3: The address/dummy phase forwards `cfg_ad_bytes` stream bytes (0..15) in stream order, MSB first. `cfg_pin_mode` selects the lanes: 0 = one lane (IO0), 1 = two lanes (IO1:IO0), 2 = four lanes (IO3:IO0), 3 = one lane. The earlier, higher-order bit of a slot goes on the higher-numbered lane, and `io_oe` enables exactly the active lanes.
- R4: When `cfg_ad_single` is 1, the address/dummy bytes use one lane on IO0 whatever the pin mode is. The data phase still uses the pin-mode lanes.
- R5: When `cfg_read` is 0 and `cfg_no_data` is 0, the data phase sends `cfg_data_len`+1 stream bytes on the pin-mode lanes, with the same bit order as R3.
- R6: When `cfg_read` is 1, every data slot has `io_oe` = 0. The sampled lanes are IO1 in one-lane mode, IO1:IO0 in two-lane mode and IO3:IO0 in four-lane mode. Bits are assembled MSB first, and each completed byte is shown on `rx_data` with a one-cycle `rx_valid` pulse. There are `cfg_data_len`+1 bytes in all.
- R7: When `cfg_no_data` is 1, the operation ends after the address/dummy phase. There are no data slots and no further stream pops. An operation with all counts zero and no data ends with no slots at all.
- R8: At a byte boundary with `tx_valid` low, a strobe is not taken. No `sck` pulse and no pop follow until a byte is offered.
- R9: `done` pulses for one cycle, in the cycle after the `sck`-high cycle of the final slot. In the next cycle `cs_n` returns to 1, `busy` falls and `io_oe` is 0.
- R10: Configuration is sampled only on `start` while idle. Changing configuration inputs or pulsing `start` during an operation has no effect, and each operation gives exactly one `done`.
- R11: Each accepted strobe gives exactly one single-cycle `sck` pulse in the next cycle, with `cs_n` low. The number of pulses equals the number of slots of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| cfg_op_bytes | input | PH_W | Opcode byte count |
| cfg_ad_bytes | input | PH_W | Combined address plus dummy byte count |
| cfg_pin_mode | input | 2 | Lane count code: 0 one, 1 two, 2 four, 3 one |
| cfg_ad_single | input | 1 | Force the address/dummy phase onto one lane |
| cfg_read | input | 1 | Data phase direction: 1 read, 0 write |
| cfg_no_data | input | 1 | Skip the data phase |
| cfg_data_len | input | DLEN_W | Data byte count minus one |
| shift_en | input | 1 | Bit-slot strobe from the clock divider |
| tx_data | input | 8 | Outgoing stream byte |
| tx_valid | input | 1 | Outgoing byte offered |
| tx_ready | output | 1 | Byte taken this cycle |
| io_in | input | 4 | Sampled IO lane levels |
| io_out | output | 4 | Driven IO lane levels |
| io_oe | output | 4 | Per-lane output enable |
| sck | output | 1 | Serial clock pulse |
| cs_n | output | 1 | Chip select, active low |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte pulse |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |

## Verification
The hardest situations to reach are the lane-width changes at phase boundaries. Examples are a single-lane address followed by a four-lane read, a last slot that lands right on a pending stream stall, and a zero-slot operation whose `done` follows `start` at once. The stimulus mixes directed operations for each of these with randomly drawn phase counts, pin modes, direction and flag settings, random stream stalls and irregular strobe spacing. While the operation runs, the bench also scrambles the configuration inputs and pulses `start` again. A device model in the bench compares every slot's lane levels and enables with a slot list computed from the requirements. It drives read bits that change only after each `sck` pulse.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADR,
    PH_DAT,
    PH_FIN
  } phase_t;

  // lane code: 0 -> one lane, 1 -> two lanes, 2 -> four lanes
  function automatic logic [1:0] lane_code(input logic [1:0] pin_mode);
    return (pin_mode == 2'd3) ? 2'd0 : pin_mode;
  endfunction

  // index of the final slot of a byte for a lane code
  function automatic logic [2:0] last_slot(input logic [1:0] lc);
    case (lc)
      2'd0:    return 3'd7;
      2'd1:    return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/mfs_phase_ctrl.sv
module mfs_phase_ctrl
  import mfs_pkg::*;
#(
  parameter int PH_W   = 4,
  parameter int DLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PH_W-1:0]   cfg_op_bytes,
  input  logic [PH_W-1:0]   cfg_ad_bytes,
  input  logic [1:0]        cfg_pin_mode,
  input  logic              cfg_ad_single,
  input  logic              cfg_read,
  input  logic              cfg_no_data,
  input  logic [DLEN_W-1:0] cfg_data_len,
  input  logic              shift_en,
  input  logic              tx_valid,
  output logic              tx_pop,
  output logic              slot_go,
  output logic              slot_end,
  output logic              slot_last,
  output logic              rd_phase,
  output logic              op_end,
  output logic [1:0]        lane_sel,
  output logic              sck,
  output logic              cs_n,
  output logic              busy,
  output logic              done
);

  localparam int CNT_W = (PH_W > DLEN_W) ? PH_W : DLEN_W;

  typedef struct packed {
    phase_t           ph;
    logic [CNT_W-1:0] cnt;
  } step_t;

  // next phase after the one given, skipping empty phases
  function automatic step_t advance(input phase_t from,
                                    input logic [PH_W-1:0] opb,
                                    input logic [PH_W-1:0] adb,
                                    input logic nod,
                                    input logic [DLEN_W-1:0] dl);
    step_t r;
    r.ph  = PH_FIN;
    r.cnt = '0;
    if (from == PH_IDLE && opb != '0) begin
      r.ph  = PH_OPC;
      r.cnt = CNT_W'(opb - 1'b1);
    end else if ((from == PH_IDLE || from == PH_OPC) && adb != '0) begin
      r.ph  = PH_ADR;
      r.cnt = CNT_W'(adb - 1'b1);
    end else if (from != PH_DAT && !nod) begin
      r.ph  = PH_DAT;
      r.cnt = CNT_W'(dl);
    end
    return r;
  endfunction

  phase_t            state;
  logic [CNT_W-1:0]  bcnt;
  logic [2:0]        scnt;
  logic              sck_q;
  logic [PH_W-1:0]   op_l, ad_l;
  logic [1:0]        mode_l;
  logic              single_l, read_l, nod_l;
  logic [DLEN_W-1:0] dlen_l;
  logic              in_slots, need_byte;
  step_t             st_start, st_next;

  assign st_start = advance(PH_IDLE, cfg_op_bytes, cfg_ad_bytes, cfg_no_data, cfg_data_len);
  assign st_next  = advance(state, op_l, ad_l, nod_l, dlen_l);

  always_comb begin
    case (state)
      PH_ADR:  lane_sel = single_l ? 2'd0 : lane_code(mode_l);
      PH_DAT:  lane_sel = lane_code(mode_l);
      default: lane_sel = 2'd0;
    endcase
  end

  assign in_slots  = (state == PH_OPC) || (state == PH_ADR) || (state == PH_DAT);
  assign rd_phase  = (state == PH_DAT) && read_l;
  assign need_byte = in_slots && !rd_phase && (scnt == 3'd0);
  assign slot_go   = shift_en && in_slots && !sck_q && (!need_byte || tx_valid);
  assign tx_pop    = slot_go && need_byte;
  assign slot_end  = sck_q;
  assign slot_last = (scnt == last_slot(lane_sel));
  assign op_end    = (state == PH_FIN);
  assign sck       = sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PH_IDLE;
      bcnt     <= '0;
      scnt     <= '0;
      sck_q    <= 1'b0;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      op_l     <= '0;
      ad_l     <= '0;
      mode_l   <= '0;
      single_l <= 1'b0;
      read_l   <= 1'b0;
      nod_l    <= 1'b0;
      dlen_l   <= '0;
    end else begin
      done  <= 1'b0;
      sck_q <= slot_go;
      case (state)
        PH_IDLE: begin
          if (start) begin
            op_l     <= cfg_op_bytes;
            ad_l     <= cfg_ad_bytes;
            mode_l   <= cfg_pin_mode;
            single_l <= cfg_ad_single;
            read_l   <= cfg_read;
            nod_l    <= cfg_no_data;
            dlen_l   <= cfg_data_len;
            state    <= st_start.ph;
            bcnt     <= st_start.cnt;
            scnt     <= '0;
            cs_n     <= 1'b0;
            busy     <= 1'b1;
            done     <= (st_start.ph == PH_FIN);
          end
        end
        PH_OPC, PH_ADR, PH_DAT: begin
          if (slot_end) begin
            if (slot_last) begin
              scnt <= '0;
              if (bcnt == '0) begin
                state <= st_next.ph;
                bcnt  <= st_next.cnt;
                done  <= (st_next.ph == PH_FIN);
              end else begin
                bcnt <= bcnt - 1'b1;
              end
            end else begin
              scnt <= scnt + 3'd1;
            end
          end
        end
        default: begin
          state <= PH_IDLE;
          cs_n  <= 1'b1;
          busy  <= 1'b0;
        end
      endcase
    end
  end

  AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (rst)
    done |=> (cs_n && !busy)); // R9
  AST_NO_SCK_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck); // R11
  AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> tx_valid); // R8
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(mode_l) && $stable(read_l) && $stable(dlen_l))); // R10

endmodule

// File: rtl/mfs_lane_dp.sv
module mfs_lane_dp #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_go,
  input  logic             byte_load,
  input  logic             slot_end,
  input  logic             slot_last,
  input  logic             rd_phase,
  input  logic             op_end,
  input  logic [1:0]       lane_sel,
  input  logic [7:0]       tx_data,
  input  logic [LANES-1:0] io_in,
  output logic [LANES-1:0] io_out,
  output logic [LANES-1:0] io_oe,
  output logic [7:0]       rx_data,
  output logic             rx_valid
);

  logic [7:0]       shreg, src, sh_next;
  logic [7:0]       rxsh, rx_next;
  logic [LANES-1:0] tx_bits, lane_on;

  assign src = byte_load ? tx_data : shreg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_on[g] = (3'(g) < (3'd1 << lane_sel));
  end

  always_comb begin
    case (lane_sel)
      2'd0: begin
        tx_bits = {3'b000, src[7]};
        sh_next = {src[6:0], 1'b0};
        rx_next = {rxsh[6:0], io_in[1]};
      end
      2'd1: begin
        tx_bits = {2'b00, src[7:6]};
        sh_next = {src[5:0], 2'b00};
        rx_next = {rxsh[5:0], io_in[1:0]};
      end
      default: begin
        tx_bits = src[7:4];
        sh_next = {src[3:0], 4'b0000};
        rx_next = {rxsh[3:0], io_in[3:0]};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      rxsh     <= '0;
      io_out   <= '0;
      io_oe    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (op_end) begin
        io_out <= '0;
        io_oe  <= '0;
      end else if (slot_go) begin
        shreg <= sh_next;
        if (rd_phase) begin
          io_out <= '0;
          io_oe  <= '0;
        end else begin
          io_out <= tx_bits;
          io_oe  <= lane_on;
        end
      end
      if (slot_end && rd_phase) begin
        rxsh <= rx_next;
        if (slot_last) begin
          rx_data  <= rx_next;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  AST_READ_RELEASES_LANES: assert property (@(posedge clk) disable iff (rst)
    (rd_phase && slot_end) |-> (io_oe == '0)); // R6
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R6
  AST_END_CLEARS_OE: assert property (@(posedge clk) disable iff (rst)
    op_end |=> (io_oe == '0)); // R9

endmodule

// File: rtl/mflash_phase_seq.sv
module mflash_phase_seq #(
  parameter int PH_W   = 4,
  parameter int DLEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PH_W-1:0]   cfg_op_bytes,
  input  logic [PH_W-1:0]   cfg_ad_bytes,
  input  logic [1:0]        cfg_pin_mode,
  input  logic              cfg_ad_single,
  input  logic              cfg_read,
  input  logic              cfg_no_data,
  input  logic [DLEN_W-1:0] cfg_data_len,
  input  logic              shift_en,
  input  logic [7:0]        tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              sck,
  output logic              cs_n,
  output logic [7:0]        rx_data,
  output logic              rx_valid,
  output logic              busy,
  output logic              done
);

  localparam int LANES = 4;

  logic       slot_go, slot_end, slot_last, rd_phase, op_end;
  logic [1:0] lane_sel;

  mfs_phase_ctrl #(.PH_W(PH_W), .DLEN_W(DLEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .cfg_op_bytes(cfg_op_bytes), .cfg_ad_bytes(cfg_ad_bytes),
    .cfg_pin_mode(cfg_pin_mode), .cfg_ad_single(cfg_ad_single),
    .cfg_read(cfg_read), .cfg_no_data(cfg_no_data), .cfg_data_len(cfg_data_len),
    .shift_en(shift_en), .tx_valid(tx_valid), .tx_pop(tx_ready),
    .slot_go(slot_go), .slot_end(slot_end), .slot_last(slot_last),
    .rd_phase(rd_phase), .op_end(op_end), .lane_sel(lane_sel),
    .sck(sck), .cs_n(cs_n), .busy(busy), .done(done)
  );

  mfs_lane_dp #(.LANES(LANES)) u_dp (
    .clk(clk), .rst(rst), .slot_go(slot_go), .byte_load(tx_ready),
    .slot_end(slot_end), .slot_last(slot_last), .rd_phase(rd_phase),
    .op_end(op_end), .lane_sel(lane_sel), .tx_data(tx_data), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .rx_data(rx_data), .rx_valid(rx_valid)
  );

endmodule

// File: tb/sim_mflash_phase_seq.sv
module sim_mflash_phase_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  cfg_op_bytes = '0, cfg_ad_bytes = '0;
  logic [1:0]  cfg_pin_mode = '0;
  logic        cfg_ad_single = 1'b0, cfg_read = 1'b0, cfg_no_data = 1'b0;
  logic [15:0] cfg_data_len = '0;
  logic        shift_en = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [3:0]  io_in = '0;
  logic [3:0]  io_out, io_oe;
  logic        sck, cs_n, rx_valid, busy, done;
  logic [7:0]  rx_data;

  always #2 clk = ~clk;

  mflash_phase_seq u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] txq [0:127];
  logic [7:0] rdq [0:63];
  logic [3:0] e_out [0:1023];
  logic [3:0] e_oe [0:1023];
  logic [3:0] e_in [0:1023];
  int n_tx, n_rd, n_slots;
  int pops = 0, pop_base = 0, stall_pct = 0;
  bit hold_tx = 0, mon_on = 0, seen = 0, done_seen = 0, prev_sck = 0;
  int slot_idx, bad_slot, rx_idx, rx_bad, done_cnt, sck_long;
  int cyc = 0, last_sck = -1, done_cyc = -1;

  task automatic chk(input string what, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int lcf(input int mode);
    return (mode == 3) ? 0 : mode;
  endfunction

  task automatic add_byte(input logic [7:0] b, input int lc, input bit rd);
    int w;
    w = 1 << lc;
    for (int s = 0; s < 8 / w; s++) begin
      logic [3:0] bits;
      bits = 4'((32'(b) >> (8 - w * (s + 1))) & ((1 << w) - 1));
      if (rd) begin
        e_oe[n_slots]  = 4'b0;
        e_out[n_slots] = 4'b0;
        e_in[n_slots]  = (lc == 0) ? {2'b00, bits[0], 1'b0} : bits;
      end else begin
        e_oe[n_slots]  = 4'((1 << w) - 1);
        e_out[n_slots] = bits;
        e_in[n_slots]  = 4'b0;
      end
      n_slots++;
    end
  endtask

  // pops counted at the edge where the handshake happens
  always @(posedge clk) if (tx_valid && tx_ready) pops <= pops + 1;

  // stimulus driver
  always @(negedge clk) begin
    int idx;
    cyc++;
    idx = pops - pop_base;
    shift_en = (cyc % 3 == 0) && ($urandom % 8 != 0);
    tx_valid = !hold_tx && (idx < n_tx) && (int'($urandom % 100) >= stall_pct);
    tx_data  = tx_valid ? txq[idx] : 8'($urandom);
  end

  // device model and monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (sck) begin
        if (prev_sck) sck_long++;
        if (!seen) begin
          if (slot_idx >= n_slots || cs_n) bad_slot++;
          else if (io_oe != e_oe[slot_idx] ||
                   (e_oe[slot_idx] != 0 && (io_out & e_oe[slot_idx]) != e_out[slot_idx]))
            bad_slot++;
        end
        seen = 1;
        last_sck = cyc;
      end else if (seen) begin
        slot_idx++;
        seen = 0;
      end
      io_in = (slot_idx < n_slots) ? e_in[slot_idx] : 4'b0;
      if (rx_valid) begin
        if (rx_idx >= n_rd || rx_data != rdq[rx_idx]) rx_bad++;
        rx_idx++;
      end
      if (done) begin
        done_seen = 1;
        done_cnt++;
        done_cyc = cyc;
      end
    end
    prev_sck = sck;
  end

  task automatic run_op(input string tag, input int opn, input int adn, input int mode,
                        input bit xm, input bit rd, input bit nod, input int dlen,
                        input int stall, input bit hold);
    int ac;
    logic [7:0] b;
    n_slots = 0; n_tx = 0; n_rd = 0;
    for (int i = 0; i < opn; i++) begin
      b = 8'($urandom); txq[n_tx] = b; n_tx++; add_byte(b, 0, 0);
    end
    ac = xm ? 0 : lcf(mode);
    for (int i = 0; i < adn; i++) begin
      b = (i >= adn - adn / 3) ? 8'hFF : 8'($urandom);
      txq[n_tx] = b; n_tx++; add_byte(b, ac, 0);
    end
    if (!nod) begin
      for (int i = 0; i <= dlen; i++) begin
        b = 8'($urandom);
        if (rd) begin rdq[n_rd] = b; n_rd++; add_byte(b, lcf(mode), 1); end
        else begin txq[n_tx] = b; n_tx++; add_byte(b, lcf(mode), 0); end
      end
    end
    @(negedge clk);
    slot_idx = 0; seen = 0; bad_slot = 0; rx_idx = 0; rx_bad = 0; sck_long = 0;
    done_seen = 0; done_cnt = 0; last_sck = -1; done_cyc = -1;
    stall_pct = stall; pop_base = pops; hold_tx = hold;
    io_in = (n_slots > 0) ? e_in[0] : 4'b0;
    cfg_op_bytes = 4'(opn); cfg_ad_bytes = 4'(adn); cfg_pin_mode = 2'(mode);
    cfg_ad_single = xm; cfg_read = rd; cfg_no_data = nod; cfg_data_len = 16'(dlen);
    start = 1'b1; mon_on = 1;
    @(negedge clk);
    start = 1'b0;
    // R10: scramble configuration once the operation has begun
    cfg_op_bytes = 4'($urandom); cfg_ad_bytes = 4'($urandom); cfg_pin_mode = 2'($urandom);
    cfg_ad_single = 1'($urandom); cfg_read = 1'($urandom); cfg_no_data = 1'($urandom);
    cfg_data_len = 16'($urandom);
    if (hold) begin
      repeat (40) @(negedge clk);
      chk({tag, " R8 no slot while stream empty"}, slot_idx == 0 && !seen && pops == pop_base,
          pops - pop_base, 0);
      hold_tx = 0;
    end
    repeat (3) @(negedge clk);
    if (n_slots >= 8) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done_seen) @(negedge clk);
    @(negedge clk);
    chk({tag, " R9 cs released after done"}, cs_n && !busy && io_oe == 0, {cs_n, busy}, 2);
    repeat (3) @(negedge clk);
    chk({tag, " slot lanes/enables"}, bad_slot == 0, bad_slot, 0);
    chk({tag, " R11 sck pulse count"}, slot_idx == n_slots && sck_long == 0, slot_idx, n_slots);
    chk({tag, " R5 R7 stream pops"}, pops - pop_base == n_tx, pops - pop_base, n_tx);
    chk({tag, " R6 read bytes"}, rx_bad == 0 && rx_idx == n_rd, rx_idx, n_rd);
    chk({tag, " R10 single done"}, done_cnt == 1, done_cnt, 1);
    if (n_slots > 0)
      chk({tag, " R9 done timing"}, done_cyc == last_sck + 1, done_cyc - last_sck, 1);
    mon_on = 0;
  endtask

  initial begin
    void'($urandom(32'd7741));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", cs_n && !sck && io_oe == 0 && !done && !busy && !rx_valid && !tx_ready,
        {cs_n, sck, io_oe, done, busy, rx_valid, tx_ready}, 10'h200);
    run_op("R2 R5 single write",      1, 3, 0, 0, 0, 0, 3, 0, 0);
    run_op("R3 dual write",           1, 4, 1, 0, 0, 0, 5, 20, 0);
    run_op("R3 R6 quad read",         1, 4, 2, 0, 1, 0, 7, 10, 0);
    run_op("R4 single addr quad read",1, 3, 2, 1, 1, 0, 4, 0, 0);
    run_op("R4 single addr dual wr",  1, 2, 1, 1, 0, 0, 2, 0, 0);
    run_op("R7 no data",              1, 5, 2, 0, 1, 1, 9, 0, 0);
    run_op("R7 empty op",             0, 0, 0, 0, 0, 1, 0, 0, 0);
    run_op("R2 two opcode bytes",     2, 0, 0, 0, 0, 1, 0, 0, 0);
    run_op("R3 max addr dummy",       1, 15, 2, 0, 1, 0, 0, 0, 0);
    run_op("R3 pin mode 3",           1, 2, 3, 0, 1, 0, 2, 0, 0);
    run_op("R8 stalled stream",       1, 2, 1, 0, 0, 0, 3, 50, 1);
    for (int k = 0; k < 12; k++)
      run_op("R5 R6 random", int'($urandom % 3), int'($urandom % 16), int'($urandom % 4),
             1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 20),
             int'($urandom % 60), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule